// File: doc/BRIEF.md
# Ahead-Pipelined Next-Trace Predictor

This block predicts which trace the fetch engine should request next. It spreads the table lookup over several clock cycles and still accepts one lookup per cycle. When a lookup is accepted, the identifier of the trace just fetched selects a group of adjacent candidate entries. That history is stale by the time the prediction is used, because the traces that follow it are still in flight. The whole group is then carried down the pipeline. In the last cycle before the result is registered, the freshest trace identifier on the input is folded into an offset. The offset picks one candidate from the group.

The pipeline depth (1 to 5) and the group size (1, 2, 4 or 8) are parameters. A deeper pipeline lets a larger table meet the cycle time. A misprediction is handled by pulsing the flush input. The flush throws away everything in flight, and the output stays quiet for as many cycles as the pipeline is deep. Each prediction comes out together with the group and offset it was read from. Training hands those values back on the update port to rewrite exactly that entry.

Top module: `atp_predictor`

## Requirements
- R1: While reset is high, and after it until an accepted lookup has passed through the pipeline, `pred_valid` is 0.
- R2: A lookup is accepted in a cycle where `lk_valid` is 1 and `flush` is 0. Each accepted lookup yields exactly one cycle with `pred_valid` high, DEPTH cycles after the cycle in which it was accepted. Lookups accepted in consecutive cycles give predictions in consecutive cycles.
- R3: The group read for a lookup is `lk_tid[GI_W-1:0]` of the accepted lookup, where GI_W = clog2(N_GROUPS). `pred_grp` reports this group.
- R4: The offset inside the group is `t[OFF_W-1:0] XOR t[ID_W-1:ID_W-OFF_W]`, where OFF_W = clog2(GRP) and t is the `lk_tid` present DEPTH-1 cycles after the lookup was accepted (the same cycle when DEPTH is 1). `pred_off` reports this offset, which is always 0 when GRP is 1.
- R5: `pred_tid` equals the table entry at (`pred_grp`, `pred_off`) as it stood when the lookup was accepted.
- R6: A cycle with `upd_valid` high writes `upd_tid` into the single entry (`upd_grp`, `upd_off`) and leaves every other entry unchanged. A lookup accepted in the next cycle already reads the new value.
- R7: A cycle with `flush` high discards every lookup accepted before it, together with any lookup presented in that same cycle. `pred_valid` is then 0 for the DEPTH cycles that follow the flush.
- R8: A cycle with `lk_valid` low produces no prediction: `pred_valid` is 0 DEPTH cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Start a lookup this cycle |
| lk_tid | input | ID_W | Newest trace identifier; selects the group for a new lookup and the offset for the one finishing |
| flush | input | 1 | Misprediction: discard all lookups in flight |
| upd_valid | input | 1 | Write one table entry |
| upd_grp | input | GI_W | Group of the entry to write |
| upd_off | input | OFF_W | Offset of the entry inside its group |
| upd_tid | input | ID_W | Trace identifier to store |
| pred_valid | output | 1 | A prediction is present |
| pred_tid | output | ID_W | Predicted next trace identifier |
| pred_grp | output | GI_W | Group the prediction was read from |
| pred_off | output | OFF_W | Offset the prediction was read from |

## Verification
The bench drives a misaligned stage register by pairing every lookup with the lookup-time group and the fresh-tid offset, and checking all of them in the one cycle where the output must appear. A slip of a single cycle anywhere in the pipeline shows up either as a wrong `pred_off`, when the offset comes from the wrong tid, or as `pred_valid` landing one cycle early or late. Either one is caught on the first lookup after the fault. A lane write-enable that decodes the wrong lane corrupts a neighbouring entry. That corruption appears as a wrong `pred_tid` as soon as the group is read again. A flush that leaves a stage valid bit set lets a prediction escape into the window of DEPTH quiet cycles that follows the flush.

// File: rtl/atp_pkg.sv
package atp_pkg;
  localparam int unsigned MAX_DEPTH = 5;

  // Index width for n items, never below one bit.
  function automatic int unsigned width_of(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  function automatic bit legal_group(input int unsigned g);
    return (g == 1) || (g == 2) || (g == 4) || (g == 8);
  endfunction
endpackage

// File: rtl/atp_lane_ram.sv
// One candidate lane: every group holds one entry of this lane.
module atp_lane_ram #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned DW      = 8,
  parameter bit          SYNC_RD = 1'b1,
  localparam int unsigned AW     = atp_pkg::width_of(ENTRIES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (SYNC_RD) begin : g_sync
      // Registered read, returns the old word on a same-address write.
      always_ff @(posedge clk) rdata <= mem[raddr];
    end else begin : g_async
      assign rdata = mem[raddr];
    end
  endgenerate
endmodule

// File: rtl/atp_delay_line.sv
// Carries a stage payload and its valid bit forward by STAGES cycles.
module atp_delay_line #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  generate
    if (STAGES == 0) begin : g_pass
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end else begin : g_regs
      logic [STAGES-1:0] v;
      logic [W-1:0]      d [STAGES];

      always_ff @(posedge clk) begin
        if (rst || flush) begin
          v <= '0;
        end else begin
          v[0] <= in_valid;
          for (int k = 1; k < STAGES; k++) v[k] <= v[k-1];
        end
      end

      always_ff @(posedge clk) begin
        d[0] <= in_data;
        for (int k = 1; k < STAGES; k++) d[k] <= d[k-1];
      end

      assign out_valid = v[STAGES-1];
      assign out_data  = d[STAGES-1];

      AST_DELAY_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, STAGES)) else $error("delay line emitted without input"); // R2
    end
  endgenerate
endmodule

// File: rtl/atp_pick.sv
// Final stage: fold the freshest tid into an offset and register the chosen entry.
module atp_pick #(
  parameter int unsigned ID_W  = 8,
  parameter int unsigned GRP   = 4,
  parameter int unsigned GI_W  = 6,
  parameter int unsigned OFF_W = 2,
  localparam int unsigned ROW_W = GRP * ID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [GI_W-1:0]  in_grp,
  input  logic [ROW_W-1:0] in_row,
  input  logic [ID_W-1:0]  fresh_tid,
  output logic             pred_valid,
  output logic [ID_W-1:0]  pred_tid,
  output logic [GI_W-1:0]  pred_grp,
  output logic [OFF_W-1:0] pred_off
);
  logic [OFF_W-1:0] off_sel;
  logic [ID_W-1:0]  cand;

  generate
    if (GRP == 1) begin : g_single
      assign off_sel = '0;
    end else begin : g_fold
      assign off_sel = fresh_tid[OFF_W-1:0] ^ fresh_tid[ID_W-1 -: OFF_W];
    end
  endgenerate

  always_comb cand = in_row[off_sel*ID_W +: ID_W];

  always_ff @(posedge clk) begin
    if (rst || flush) pred_valid <= 1'b0;
    else              pred_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    pred_tid <= cand;
    pred_grp <= in_grp;
    pred_off <= off_sel;
  end

  AST_FLUSH_KILL: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_valid) else $error("prediction survived a flush"); // R7
  AST_PICK_SRC: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(in_valid)) else $error("prediction without a staged lookup"); // R2
endmodule

// File: rtl/atp_predictor.sv
module atp_predictor #(
  parameter int unsigned ID_W     = 8,
  parameter int unsigned N_GROUPS = 64,
  parameter int unsigned GRP      = 4,
  parameter int unsigned DEPTH    = 3,
  localparam int unsigned GI_W    = atp_pkg::width_of(N_GROUPS),
  localparam int unsigned OFF_W   = atp_pkg::width_of(GRP),
  localparam int unsigned ROW_W   = GRP * ID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [ID_W-1:0]  lk_tid,
  input  logic             flush,
  input  logic             upd_valid,
  input  logic [GI_W-1:0]  upd_grp,
  input  logic [OFF_W-1:0] upd_off,
  input  logic [ID_W-1:0]  upd_tid,
  output logic             pred_valid,
  output logic [ID_W-1:0]  pred_tid,
  output logic [GI_W-1:0]  pred_grp,
  output logic [OFF_W-1:0] pred_off
);
  initial begin
    AST_LEGAL_PARAMS: assert (DEPTH >= 1 && DEPTH <= atp_pkg::MAX_DEPTH &&
                              atp_pkg::legal_group(GRP) && ID_W >= GI_W && ID_W >= OFF_W)
      else $error("illegal predictor parameters");
  end

  logic             lk_go;
  logic [GI_W-1:0]  lk_grp;
  logic [ROW_W-1:0] row_rd;
  logic             fin_valid;
  logic [GI_W-1:0]  fin_grp;
  logic [ROW_W-1:0] fin_row;

  assign lk_go  = lk_valid && !flush;
  assign lk_grp = lk_tid[GI_W-1:0];

  // Candidate storage: one memory per lane, all read at the same group.
  generate
    for (genvar l = 0; l < GRP; l++) begin : g_lane
      logic lane_we;
      if (GRP == 1) begin : g_we1
        assign lane_we = upd_valid;
      end else begin : g_wen
        assign lane_we = upd_valid && (upd_off == OFF_W'(l));
      end
      atp_lane_ram #(
        .ENTRIES (N_GROUPS),
        .DW      (ID_W),
        .SYNC_RD (DEPTH > 1)
      ) u_ram (
        .clk   (clk),
        .we    (lane_we),
        .waddr (upd_grp),
        .wdata (upd_tid),
        .raddr (lk_grp),
        .rdata (row_rd[l*ID_W +: ID_W])
      );
    end
  endgenerate

  // Early stages: stale-history group read, then plain carry.
  generate
    if (DEPTH == 1) begin : g_flat
      assign fin_valid = lk_go;
      assign fin_grp   = lk_grp;
      assign fin_row   = row_rd;
    end else begin : g_piped
      logic            s1_valid;
      logic [GI_W-1:0] s1_grp;

      always_ff @(posedge clk) begin
        if (rst || flush) s1_valid <= 1'b0;
        else              s1_valid <= lk_go;
      end
      always_ff @(posedge clk) s1_grp <= lk_grp;

      atp_delay_line #(
        .W      (GI_W + ROW_W),
        .STAGES (DEPTH - 2)
      ) u_carry (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .in_valid  (s1_valid),
        .in_data   ({s1_grp, row_rd}),
        .out_valid (fin_valid),
        .out_data  ({fin_grp, fin_row})
      );
    end
  endgenerate

  atp_pick #(
    .ID_W  (ID_W),
    .GRP   (GRP),
    .GI_W  (GI_W),
    .OFF_W (OFF_W)
  ) u_pick (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .in_valid   (fin_valid),
    .in_grp     (fin_grp),
    .in_row     (fin_row),
    .fresh_tid  (lk_tid),
    .pred_valid (pred_valid),
    .pred_tid   (pred_tid),
    .pred_grp   (pred_grp),
    .pred_off   (pred_off)
  );

  AST_LOOKUP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(lk_valid && !flush, DEPTH)) else $error("prediction from an idle slot"); // R8
  AST_GRP_FROM_ISSUE: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (pred_grp == $past(lk_tid[GI_W-1:0], DEPTH))) else $error("group not from issue tid"); // R3
endmodule

// File: tb/atp_predictor_tb.sv
module atp_predictor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 8, NG = 64, GRP = 4, DEPTH = 3, GI_W = 6, OFF_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 1'b0, flush = 1'b0, upd_valid = 1'b0;
  logic [ID_W-1:0]  lk_tid = '0, upd_tid = '0;
  logic [GI_W-1:0]  upd_grp = '0;
  logic [OFF_W-1:0] upd_off = '0;
  logic pred_valid;
  logic [ID_W-1:0]  pred_tid;
  logic [GI_W-1:0]  pred_grp;
  logic [OFF_W-1:0] pred_off;

  atp_predictor #(.ID_W(ID_W), .N_GROUPS(NG), .GRP(GRP), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_tid(lk_tid), .flush(flush),
    .upd_valid(upd_valid), .upd_grp(upd_grp), .upd_off(upd_off), .upd_tid(upd_tid),
    .pred_valid(pred_valid), .pred_tid(pred_tid), .pred_grp(pred_grp), .pred_off(pred_off));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [ID_W-1:0] model [NG][GRP];
  logic [ID_W-1:0] sq_tid [64];
  bit sq_vld [64];
  bit sq_fl [64];

  typedef struct {
    int due;
    logic [ID_W-1:0] tid;
    logic [GI_W-1:0] g;
    logic [OFF_W-1:0] o;
    string req;
  } exp_t;
  exp_t sb[$];

  function automatic logic [GI_W-1:0] grp_of(logic [ID_W-1:0] t);
    return t[GI_W-1:0];
  endfunction
  function automatic logic [OFF_W-1:0] off_of(logic [ID_W-1:0] t);
    return t[1:0] ^ t[7:6];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // Monitor: pops the expected prediction due this cycle, else demands silence.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk(pred_valid && pred_tid == e.tid && pred_grp == e.g && pred_off == e.o, e.req,
            "prediction {valid,tid,grp,off}",
            {15'd0, pred_valid, pred_tid, pred_grp, pred_off},
            {15'd0, 1'b1, e.tid, e.g, e.o});
      end else begin
        chk(!pred_valid, cur_req, "pred_valid on idle slot", {31'd0, pred_valid}, 32'd0);
      end
    end
  end

  task automatic upd(int g, int o, logic [ID_W-1:0] v);
    @(negedge clk);
    upd_valid = 1'b1; upd_grp = GI_W'(g); upd_off = OFF_W'(o); upd_tid = v;
    model[g][o] = v;
  endtask

  task automatic upd_end();
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // Driver: plays sq_* and pushes expected results into the scoreboard.
  task automatic run_seq(int n, string req);
    cur_req = req;
    for (int i = 0; i < n + DEPTH; i++) begin
      @(negedge clk);
      lk_tid = sq_tid[i];
      if (i < n) begin lk_valid = sq_vld[i]; flush = sq_fl[i]; end
      else begin lk_valid = 1'b0; flush = 1'b0; end
      if (flush) begin
        for (int k = sb.size() - 1; k >= 0; k--) if (sb[k].due > cyc) sb.delete(k);
      end else if (lk_valid) begin
        exp_t e;
        e.due = cyc + DEPTH;
        e.g   = grp_of(sq_tid[i]);
        e.o   = off_of(sq_tid[i+DEPTH-1]);
        e.tid = model[e.g][e.o];
        e.req = req;
        sb.push_back(e);
      end
    end
    @(negedge clk);
    lk_valid = 1'b0; flush = 1'b0;
    repeat (DEPTH + 1) @(negedge clk);
  endtask

  task automatic fill_rand(int vld_mode);
    for (int i = 0; i < 64; i++) begin
      sq_tid[i] = ID_W'($urandom_range(0, 255));
      sq_vld[i] = (vld_mode == 0) ? 1'b1 : (i % 3 != 1);
      sq_fl[i]  = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!pred_valid, "R1", "pred_valid during reset", {31'd0, pred_valid}, 32'd0);
    rst = 1'b0;

    // Load every entry with a distinct pattern (R6 and quiet output for R1).
    cur_req = "R1";
    for (int g = 0; g < NG; g++)
      for (int o = 0; o < GRP; o++)
        upd(g, o, ID_W'(g * 7 + o * 53 + 11));
    upd_end();
    repeat (3) @(negedge clk);

    // Back-to-back lookups: latency, group, offset and entry (R2 R3 R4 R5).
    fill_rand(0);
    run_seq(40, "R2/R3/R4/R5");

    // Bubbles in the lookup stream (R8).
    fill_rand(1);
    run_seq(40, "R8");

    // Rewrite one entry, then read its whole group the next cycle (R6).
    upd(5, 2, 8'hA5);
    upd_end();
    for (int i = 0; i < 64; i++) begin
      sq_tid[i] = {2'(i % 4), 6'd5};
      sq_vld[i] = 1'b1;
      sq_fl[i]  = 1'b0;
    end
    run_seq(16, "R6");

    // Flushes inside a full stream and at its start (R7).
    fill_rand(0);
    sq_fl[12] = 1'b1;
    sq_fl[30] = 1'b1;
    sq_fl[31] = 1'b1;
    run_seq(45, "R7");
    fill_rand(0);
    sq_fl[0] = 1'b1;
    run_seq(10, "R7");

    chk(sb.size() == 0, "R2", "unconsumed expected predictions", sb.size(), 32'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule